// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. A producer pushes words on the write clock and a consumer takes them on the read clock. The two clocks are free-running and either one may be the faster. Pointers cross between the domains as Gray code through two-flop synchronisers. Each flag is computed in the domain that acts on it.

Two output timings are available, chosen by a mode pin that is captured during master reset. In standard timing the read-side flag reports empty, the write-side flag reports full, and a word reaches the output only after a read request. In fall-through timing the first word moves to the output register without any request. The read-side flag then means "output word valid" and the write-side flag means "room available". The block also provides a half-full flag and almost-empty / almost-full flags with programmable thresholds. The thresholds are loaded through the write port, either one word at a time or one bit at a time. A partial reset empties the buffer and keeps the programmed settings. A retransmit pulse rewinds the read side to the first word written since the last reset.

Top module: `pflag_fifo`

## Requirements
- R1: After master reset in standard timing, rd_flag=1, wr_flag=0, half_full=0, almost_empty=1 and almost_full=0. In fall-through timing, rd_flag=0 and wr_flag=1.
- R2: Words leave in the order they were accepted. In standard timing, dout takes the next word on the rclk edge where ren=1 and the buffer is not empty.
- R3: In standard timing, wr_flag=1 exactly when DEPTH words are stored. A write while full is dropped. A read while empty changes nothing.
- R4: half_full=1 when the write-side occupancy is greater than DEPTH/2.
- R5: almost_empty=1 when the read-side occupancy is at most the empty offset. almost_full=1 when the write-side occupancy is at least DEPTH minus the full offset.
- R6: Master reset sets both offsets to DEF_LO (3) when def_sel is low, and to DEF_HI (7) when def_sel is high.
- R7: While ld=1, each wen cycle stores din[AW-1:0] as an offset and stores nothing in the buffer. The first such cycle sets the empty offset, the next sets the full offset, and the two alternate after that.
- R8: While ld=1, sen=1 and wen=0, each wclk shifts si into bit 0 of the 2*AW-bit chain {full offset, empty offset}. The MSB of the empty offset moves into the LSB of the full offset.
- R9: Partial reset empties the buffer but keeps both offsets and the timing mode.
- R10: mode_fwft and def_sel are sampled while mrst_n is low, and later changes on those pins have no effect.
- R11: In fall-through timing, the oldest word appears on dout with rd_flag=1 and no ren. A word held on dout stays there until ren. Capacity is DEPTH+1 words.
- R12: After the wclk edge that writes into an empty buffer, the standard-timing rd_flag falls on the 2nd following rclk edge. The fall-through rd_flag rises on the 3rd.
- R13: A retransmit pulse (rt=1) sets the read pointer to location 0. In standard timing the next ren returns the first word again. In fall-through timing that word is valid one rclk after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| mode_fwft | input | 1 | Timing mode pin: 1 selects fall-through |
| def_sel | input | 1 | Default-offset select pin |
| wen | input | 1 | Write enable |
| din | input | DW | Write data, also the parallel offset value |
| ld | input | 1 | Offset-programming enable |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit pulse (read domain) |
| dout | output | DW | Output register |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or room available (fall-through) |
| half_full | output | 1 | Write-side occupancy above DEPTH/2 |
| almost_empty | output | 1 | Read-side occupancy at or below the empty offset |
| almost_full | output | 1 | Write-side occupancy at or above DEPTH minus the full offset |

## Verification
On every cycle, the assertions check these properties: the pointers hold while full, while empty and during offset loading; full implies almost-full and half-full; a drained buffer reports almost-empty; a word held on the fall-through output stays put until it is read; and a retransmit leaves the read pointer at zero. Several behaviours can only be shown by the bench's scenarios. These are the data order across two unrelated clocks, the exact flag thresholds for default, parallel and serial offsets, the kept settings after a partial reset, the rclk-edge latency of the first word, the DEPTH+1 capacity in fall-through timing, and the replayed data after a retransmit.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  // Binary to Gray conversion, callers cast to their pointer width
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary conversion, prefix XOR from the top bit down
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Occupancy from two wrapped pointers
  function automatic logic [31:0] occupancy(input logic [31:0] head, input logic [31:0] tail);
    return head - tail;
  endfunction
endpackage

// File: rtl/pflag_sync2.sv
module pflag_sync2 #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pflag_ram.sv
module pflag_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pflag_wr_ctrl.sv
module pflag_wr_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DEF_LO = 3,
  parameter int DEF_HI = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_fwft,
  input  logic          def_sel,
  input  logic          wen,
  input  logic [AW-1:0] prog_val,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic [PW-1:0] rgray_q,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  output logic          fwft,
  output logic [AW-1:0] ae_off
);
  logic [PW-1:0] wptr, wptr_nxt, rq_bin, wcount;
  logic [AW-1:0] af_off;
  logic          par_sel;
  logic          prog_par, prog_ser;

  assign rq_bin   = PW'(gray2bin(32'(rgray_q)));
  assign wcount   = PW'(occupancy(32'(wptr), 32'(rq_bin)));
  assign full     = (wcount == PW'(DEPTH));
  assign push     = wen && !ld && !full;
  assign prog_par = wen && ld;
  assign prog_ser = sen && ld && !wen;
  assign wptr_nxt = wptr + PW'(1);
  assign waddr    = wptr[AW-1:0];

  assign almost_full = (wcount >= (PW'(DEPTH) - {1'b0, af_off}));
  assign half_full   = (wcount > PW'(DEPTH / 2));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (push) begin
      wptr  <= wptr_nxt;
      wgray <= PW'(bin2gray(32'(wptr_nxt)));
    end
  end

  // Mode and offsets: captured while master reset is held, kept over partial reset
  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft    <= mode_fwft;
      ae_off  <= def_sel ? AW'(DEF_HI) : AW'(DEF_LO);
      af_off  <= def_sel ? AW'(DEF_HI) : AW'(DEF_LO);
      par_sel <= 1'b0;
    end else if (!prst_n) begin
      par_sel <= 1'b0;
    end else if (prog_par) begin
      if (!par_sel) ae_off <= prog_val;
      else          af_off <= prog_val;
      par_sel <= !par_sel;
    end else if (prog_ser) begin
      {af_off, ae_off} <= {af_off[AW-2:0], ae_off, si};
    end
  end

  a_r3_full_hold: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wptr));
  a_r7_load_no_store: assert property (@(posedge wclk) disable iff (!rst_n)
    ld |=> $stable(wptr));
  a_r5_full_has_af: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  a_r4_full_has_hf: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> half_full);
endmodule

// File: rtl/pflag_rd_ctrl.sv
module pflag_rd_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ren,
  input  logic          rt,
  input  logic [PW-1:0] wgray_q,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          almost_empty
);
  logic [PW-1:0] rptr, rptr_nxt, wq_bin, rcount;
  logic          ovalid, mem_empty, pop;

  assign wq_bin    = PW'(gray2bin(32'(wgray_q)));
  assign mem_empty = (wq_bin == rptr);
  assign rcount    = PW'(occupancy(32'(wq_bin), 32'(rptr))) + PW'(ovalid);
  assign pop       = fwft ? (!mem_empty && (!ovalid || ren)) : (ren && !mem_empty);
  assign rptr_nxt  = rptr + PW'(1);
  assign raddr     = rptr[AW-1:0];

  assign rd_flag      = fwft ? ovalid : mem_empty;
  assign almost_empty = (rcount <= {1'b0, ae_off});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      dout   <= '0;
      ovalid <= 1'b0;
    end else if (rt) begin
      rptr   <= '0;
      rgray  <= '0;
      ovalid <= 1'b0;
    end else begin
      if (pop) begin
        rptr  <= rptr_nxt;
        rgray <= PW'(bin2gray(32'(rptr_nxt)));
        dout  <= rdata;
      end
      if (fwft) ovalid <= pop || (ovalid && !ren);
    end
  end

  a_r3_empty_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    (mem_empty && !rt) |=> $stable(rptr));
  a_r11_hold_output: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && ovalid && !ren && !rt) |=> (ovalid && $stable(dout)));
  a_r13_rt_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    rt |=> (rptr == '0));
  a_r5_drained_is_ae: assert property (@(posedge rclk) disable iff (!rst_n)
    (mem_empty && !ovalid) |-> almost_empty);
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DEPTH  = 16,
  parameter int DW     = 9,
  parameter int DEF_LO = 3,
  parameter int DEF_HI = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_fwft,
  input  logic          def_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          si,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          rst_any_n;
  logic [PW-1:0] wgray, rgray, wgray_q, rgray_q;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic [DW-1:0] rdata;
  logic          push, full, fwft;

  assign rst_any_n = mrst_n & prst_n;
  assign wr_flag   = fwft ? !full : full;

  pflag_sync2 #(.WIDTH(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_any_n), .d(wgray), .q(wgray_q));

  pflag_sync2 #(.WIDTH(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_any_n), .d(rgray), .q(rgray_q));

  pflag_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata));

  pflag_wr_ctrl #(.DEPTH(DEPTH), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
    .wclk(wclk), .rst_n(rst_any_n), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_fwft(mode_fwft), .def_sel(def_sel), .wen(wen),
    .prog_val(din[AW-1:0]), .ld(ld), .sen(sen), .si(si),
    .rgray_q(rgray_q), .wgray(wgray), .waddr(waddr), .push(push),
    .full(full), .almost_full(almost_full), .half_full(half_full),
    .fwft(fwft), .ae_off(ae_off));

  pflag_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .rclk(rclk), .rst_n(rst_any_n), .fwft(fwft), .ren(ren), .rt(rt),
    .wgray_q(wgray_q), .rdata(rdata), .ae_off(ae_off), .raddr(raddr),
    .rgray(rgray), .dout(dout), .rd_flag(rd_flag),
    .almost_empty(almost_empty));
endmodule

// File: tb/pflag_fifo_tb.sv
`timescale 1ns/1ps
module pflag_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 9;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_fwft = 1'b0, def_sel = 1'b0;
  logic wen = 1'b0, ld = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0, rt = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

  int n_chk = 0, n_fail = 0;
  int mq[$];
  int hist[$];
  bit fw = 1'b0;

  always #4 wclk = ~wclk;   // 125 MHz
  always #5 rclk = ~rclk;   // unrelated read clock

  pflag_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_fwft(mode_fwft), .def_sel(def_sel), .wen(wen), .din(din),
    .ld(ld), .sen(sen), .si(si), .ren(ren), .rt(rt), .dout(dout),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic mreset(bit f, bit d);
    @(negedge wclk);
    mrst_n = 1'b0; mode_fwft = f; def_sel = d;
    repeat (3) @(negedge wclk);
    mrst_n = 1'b1;
    mode_fwft = !f;  // R10: later pin changes must not matter
    def_sel = !d;
    fw = f;
    mq.delete(); hist.delete();
    settle();
  endtask

  task automatic preset();
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (3) @(negedge wclk);
    prst_n = 1'b1;
    mq.delete(); hist.delete();
    settle();
  endtask

  // One write attempt; the model accepts it only when the flag shows room
  task automatic put(int v);
    @(negedge wclk);
    wen = 1'b1; din = DW'(v);
    if (fw ? wr_flag : !wr_flag) begin mq.push_back(v); hist.push_back(v); end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic put_settle(int v);
    put(v);
    settle();
  endtask

  task automatic pop_cmp(string r);
    int e;
    if (mq.size() == 0) chk({r, " unexpected word"}, 1, 0);
    else begin e = mq.pop_front(); chk(r, int'(dout), e); end
  endtask

  task automatic get(string r, output bit got);
    got = 1'b0;
    @(negedge rclk);
    if (fw) begin
      if (rd_flag) begin pop_cmp(r); ren = 1'b1; got = 1'b1; end
      @(negedge rclk);
      ren = 1'b0;
    end else begin
      got = !rd_flag;
      ren = 1'b1;
      @(negedge rclk);
      ren = 1'b0;
      if (got) pop_cmp(r);
    end
  endtask

  task automatic drain(string r, output int n);
    bit g;
    n = 0;
    repeat (DEPTH + 6) begin
      get(r, g);
      if (g) n++;
    end
  endtask

  task automatic pulse_rt();
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    bit g;
    mreset(1'b0, 1'b0);
    chk("R1 std rd_flag", rd_flag, 1);
    chk("R1 std wr_flag", wr_flag, 0);
    chk("R1 std half_full", half_full, 0);
    chk("R1 std almost_empty", almost_empty, 1);
    chk("R1 std almost_full", almost_full, 0);

    // R3: read while empty is ignored
    get("R3 read-empty", g);
    chk("R3 read-empty accepted", g, 0);

    // R12: standard first-word latency in rclk edges
    @(negedge wclk); wen = 1'b1; din = 9'h155; mq.push_back(9'h155); hist.push_back(9'h155);
    @(posedge wclk);
    fork begin @(negedge wclk); wen = 1'b0; end join_none
    @(posedge rclk); #2 chk("R12 std edge1 still empty", rd_flag, 1);
    @(posedge rclk); #2 chk("R12 std edge2 not empty", rd_flag, 0);
    settle();
    drain("R2 first word", n);
    chk("R2 first word count", n, 1);

    // R2: order with a mixed pattern
    for (int i = 0; i < 5; i++) put(((i * 37) ^ 9'h0A5) & 9'h1FF);
    settle();
    chk("R5 ae off at 5 words", almost_empty, 0);
    drain("R2 order", n);
    chk("R2 order count", n, 5);

    // R3/R4/R5 with default offsets 3
    for (int k = 1; k <= DEPTH; k++) begin
      put_settle(k * 29 + 1);
      if (k == 3)  chk("R5 ae at 3", almost_empty, 1);
      if (k == 4)  chk("R5 ae at 4", almost_empty, 0);
      if (k == 8)  chk("R4 hf at 8", half_full, 0);
      if (k == 9)  chk("R4 hf at 9", half_full, 1);
      if (k == 12) chk("R5 af at 12", almost_full, 0);
      if (k == 13) chk("R5 af at 13", almost_full, 1);
      if (k == 15) chk("R3 full at 15", wr_flag, 0);
      if (k == 16) chk("R3 full at 16", wr_flag, 1);
    end
    put_settle(9'h1EE);
    put_settle(9'h1DD);
    drain("R3 overflow data", n);
    chk("R3 words after overflow", n, DEPTH);

    // R7: parallel offset load, ae=5 af=2
    @(negedge wclk); ld = 1'b1; wen = 1'b1; din = 9'd5;
    @(negedge wclk); din = 9'd2;
    @(negedge wclk); wen = 1'b0; ld = 1'b0;
    settle();
    chk("R7 load stores nothing", rd_flag, 1);
    for (int k = 1; k <= 14; k++) begin
      put_settle(k + 9'h100);
      if (k == 5)  chk("R7 ae at 5", almost_empty, 1);
      if (k == 6)  chk("R7 ae at 6", almost_empty, 0);
      if (k == 13) chk("R7 af at 13", almost_full, 0);
      if (k == 14) chk("R7 af at 14", almost_full, 1);
    end
    drain("R7 data", n);

    // R8: serial load, chain {af,ae} = 0100_0001 sent first bit first
    @(negedge wclk); ld = 1'b1; sen = 1'b1;
    foreach (hist[i]) ;
    for (int b = 7; b >= 0; b--) begin
      si = (8'b0100_0001 >> b) & 1;
      @(negedge wclk);
    end
    ld = 1'b0; sen = 1'b0; si = 1'b0;
    settle();
    for (int k = 1; k <= 12; k++) begin
      put_settle(k * 3);
      if (k == 1)  chk("R8 ae at 1", almost_empty, 1);
      if (k == 2)  chk("R8 ae at 2", almost_empty, 0);
      if (k == 11) chk("R8 af at 11", almost_full, 0);
      if (k == 12) chk("R8 af at 12", almost_full, 1);
    end
    drain("R8 data", n);

    // R9: partial reset empties but keeps offsets (ae=1)
    for (int k = 0; k < 3; k++) put(k + 40);
    settle();
    preset();
    chk("R9 empty after prst", rd_flag, 1);
    chk("R9 hf after prst", half_full, 0);
    put_settle(9'h0C3);
    chk("R9 kept ae at 1", almost_empty, 1);
    put_settle(9'h0C4);
    chk("R9 kept ae at 2", almost_empty, 0);
    drain("R9 data", n);
    chk("R9 words after prst", n, 2);

    // R6: def_sel high selects 7
    mreset(1'b0, 1'b1);
    for (int k = 1; k <= 9; k++) begin
      put_settle(k + 200);
      if (k == 7) chk("R6 ae at 7", almost_empty, 1);
      if (k == 8) begin chk("R6 ae at 8", almost_empty, 0); chk("R6 af at 8", almost_full, 0); end
      if (k == 9) chk("R6 af at 9", almost_full, 1);
    end
    drain("R6 data", n);

    // R13: standard retransmit
    mreset(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) put(9'h0F0 + k);
    settle();
    drain("R13 first pass", n);
    pulse_rt();
    mq = hist;
    settle();
    chk("R13 std not empty after rt", rd_flag, 0);
    drain("R13 replay", n);
    chk("R13 replay count", n, 4);

    // Fall-through timing
    mreset(1'b1, 1'b0);
    chk("R1 fwft rd_flag", rd_flag, 0);
    chk("R1 fwft wr_flag", wr_flag, 1);
    @(negedge wclk); wen = 1'b1; din = 9'h0AB; mq.push_back(9'h0AB); hist.push_back(9'h0AB);
    @(posedge wclk);
    fork begin @(negedge wclk); wen = 1'b0; end join_none
    @(posedge rclk); #2;
    @(posedge rclk); #2 chk("R12 fwft edge2 not ready", rd_flag, 0);
    @(posedge rclk); #2 chk("R12 fwft edge3 ready", rd_flag, 1);
    chk("R11 fall-through data", int'(dout), 9'h0AB);
    settle();
    chk("R11 held without ren", int'(dout), 9'h0AB);
    chk("R10 mode kept after pin change", rd_flag, 1);
    drain("R11 first", n);

    for (int k = 0; k < DEPTH + 3; k++) put_settle(k + 300);
    chk("R11 no room at capacity", wr_flag, 0);
    drain("R11 capacity data", n);
    chk("R11 capacity words", n, DEPTH + 1);

    // R9 mode kept over partial reset, then R13 fall-through retransmit
    preset();
    chk("R9 fwft kept rd_flag", rd_flag, 0);
    chk("R9 fwft kept wr_flag", wr_flag, 1);
    for (int k = 0; k < 3; k++) put(k + 77);
    settle();
    drain("R13 fwft first pass", n);
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
    chk("R13 fwft not ready at rt edge", rd_flag, 0);
    @(negedge rclk);
    chk("R13 fwft ready one rclk later", rd_flag, 1);
    chk("R13 fwft first word again", int'(dout), 77);
    mq = hist;
    drain("R13 fwft replay", n);
    chk("R13 fwft replay count", n, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule